// File: doc/BRIEF.md
# Two-Level IO Address Translation Walker

This block turns a 32-bit device virtual address into a 36-bit physical address. It walks a two-level translation table held in system memory. A client hands over the address, a read/write flag and the physical base of the top-level table. The walker then reads one or two 32-bit descriptors through a simple request/response memory port, with at most one read in flight. It returns either a physical address with a mapping-size code, or a fault code.

Descriptors hold physical addresses pre-shifted right by four bits, which is why the output is 36 bits wide. A top-level descriptor can map a 1 MB section directly, or it can point at a 256-entry second-level table. A second-level descriptor maps a 64 KB large page or a 4 KB small page. The two levels decode their type field with different widths.

Every interface uses valid/ready handshaking. Only one translation is in progress at a time, and the result stays on the outputs until the client takes it.

Top module: `iopt_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress and no result is pending. A request is taken on a cycle with `req_valid` and `req_ready` both high. Request inputs presented while busy are ignored and do not change the result.
- R2: The first memory read goes to `tbl_base + 4 * vaddr[31:20]`, using a 36-bit add.
- R3: The low three bits of the first-level descriptor select its kind: 0 is a page fault, 1 is a table pointer, 2 is a section, and 3 to 7 are page faults. A page fault reports `rsp_fault`=1, `rsp_code`=1, `rsp_size`=0 and `rsp_paddr`=0.
- R4: A section result has `rsp_paddr` = {descriptor[31:16], vaddr[19:0]} and `rsp_size`=2. The size codes are 0 for 4 KB, 1 for 64 KB and 2 for 1 MB.
- R5: The second memory read goes to {first-level descriptor[31:6], vaddr[19:12], 2'b00}.
- R6: The low two bits of the second-level descriptor select its kind: 0 is a page fault, 1 is a large page with `rsp_paddr` = {descriptor[31:12], vaddr[15:0]} and size 1, 2 is a small page with `rsp_paddr` = {descriptor[31:8], vaddr[11:0]} and size 0, and 3 is a page fault.
- R7: A read response with `mem_rsp_err`=1 ends the walk with `rsp_fault`=1, `rsp_code`=0 and `rsp_paddr`=0. No further read is issued. Faults only ever carry code 0 or 1.
- R8: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. No new read is issued before the previous response arrives. No read is issued while a result is pending.
- R9: The result, including `rsp_write` (the request's write flag), holds steady while `rsp_valid` is high and `rsp_ready` is low. `req_ready` is high in the cycle after the result is accepted.
- R10: With a memory that accepts at once and answers in the cycle after acceptance, `rsp_valid` rises on the 3rd rising edge after the request is accepted for a walk that ends at level one. It rises on the 5th rising edge for a two-level walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write |
| tbl_base | input | 36 | Physical base of the first-level table |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read ended in error |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Client takes the result |
| rsp_fault | output | 1 | Translation faulted |
| rsp_code | output | 3 | Fault cause: 0 table read error, 1 page fault |
| rsp_size | output | 2 | Mapping size: 0 4 KB, 1 64 KB, 2 1 MB |
| rsp_paddr | output | 36 | Translated physical address |
| rsp_write | output | 1 | Write flag of the translated request |

## Verification
With a zero-wait memory model, a level-one outcome (section, first-level fault or first-level read error) is due 3 edges after request acceptance. A two-level outcome is due 5 edges after acceptance.

The bench drives every input and samples every output on falling edges only. It counts the falling edges from acceptance to the first one where `rsp_valid` is seen, and compares that count with 3 or 5 according to the expected number of reads. Each read address is compared on the falling edge before the edge that accepts it. Response data is driven on the falling edge after acceptance.

Separate runs stall the memory and the client to show that held outputs do not move, and that the walker ignores request inputs while it is busy.

// File: rtl/iopt_pkg.sv
// Shared widths, field positions and encodings for the IO table walker.
// Assumes 32-bit descriptors that hold physical addresses shifted right by 4.
package iopt_pkg;

    localparam int VA_W        = 32;                    // device virtual address width
    localparam int DESC_W      = 32;                    // descriptor word width
    localparam int DESC_SHIFT  = 4;                     // descriptor address pre-shift
    localparam int PA_W        = DESC_W + DESC_SHIFT;   // physical address width
    localparam int L1_SHIFT    = 20;                    // section size order
    localparam int LARGE_SHIFT = 16;                    // large page size order
    localparam int L2_SHIFT    = 12;                    // small page size order
    localparam int L2_TBL_LOW  = 6;                     // low bits cleared for table pointer
    localparam int WORD_LSB    = 2;                     // byte offset bits of a descriptor word
    localparam int L1_TYPE_W   = 3;                     // first-level type field width
    localparam int L2_TYPE_W   = 2;                     // second-level type field width
    localparam int CODE_W      = 3;                     // fault code width

    // Descriptor bit from which each mapping keeps its base
    localparam int SECT_KEEP  = L1_SHIFT - DESC_SHIFT;
    localparam int LARGE_KEEP = LARGE_SHIFT - DESC_SHIFT;
    localparam int SMALL_KEEP = L2_SHIFT - DESC_SHIFT;
    localparam int TBL_W      = DESC_W - L2_TBL_LOW;

    typedef enum logic [CODE_W-1:0] {
        FLT_WALK    = 3'd0,
        FLT_PAGE    = 3'd1,
        FLT_UNKNOWN = 3'd5
    } flt_e;

    typedef enum logic [1:0] {
        SZ_SMALL   = 2'd0,
        SZ_LARGE   = 2'd1,
        SZ_SECTION = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        L1K_FAULT,
        L1K_TABLE,
        L1K_LEAF
    } l1_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic            fault;
        flt_e            code;
        size_e           size;
        logic [PA_W-1:0] paddr;
    } walk_res_t;

endpackage

// File: rtl/iopt_addr_gen.sv
// Descriptor read address generator.
// Level one adds the scaled top index to the table base.
// Level two concatenates the table pointer with the scaled second index.
// That is exact because a second-level table is 1 KB and 1 KB aligned.
module iopt_addr_gen
    import iopt_pkg::*;
(
    input  logic [PA_W-1:0]  tbl_base,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [TBL_W-1:0] l2_tbl,
    input  logic             sel_l2,
    output logic [PA_W-1:0]  rd_addr
);

    logic [PA_W-1:0] l1_off;
    logic [PA_W-1:0] l1_addr;
    logic [PA_W-1:0] l2_addr;

    // Form both candidate addresses and pick the one for the current level
    always_comb begin
        l1_off  = PA_W'({vaddr[VA_W-1:L1_SHIFT], {WORD_LSB{1'b0}}});
        l1_addr = tbl_base + l1_off;
        l2_addr = {l2_tbl, vaddr[L1_SHIFT-1:L2_SHIFT], {WORD_LSB{1'b0}}};
        rd_addr = sel_l2 ? l2_addr : l1_addr;
    end

endmodule

// File: rtl/iopt_l1_decode.sv
// First-level descriptor decoder.
// Classifies the word as a fault, a table pointer or a section.
// For a section it builds the final result. Type values above 2 are faults.
module iopt_l1_decode
    import iopt_pkg::*;
(
    input  logic [DESC_W-1:0]   desc,
    input  logic [L1_SHIFT-1:0] va_off,
    output l1_kind_e            kind,
    output walk_res_t           res
);

    logic [L1_TYPE_W-1:0] typ;
    logic                 unused_l1_bits;

    assign typ            = desc[L1_TYPE_W-1:0];
    assign unused_l1_bits = ^desc[SECT_KEEP-1:L1_TYPE_W];

    // Decode the type field and assemble a section translation
    always_comb begin
        res = '{fault: 1'b1, code: FLT_PAGE, size: SZ_SMALL, paddr: '0};
        kind = L1K_FAULT;
        case (typ)
            3'd1: begin
                kind = L1K_TABLE;
                res.fault = 1'b0;
                res.code  = FLT_WALK;
            end
            3'd2: begin
                kind = L1K_LEAF;
                res = '{fault: 1'b0, code: FLT_WALK, size: SZ_SECTION,
                        paddr: {desc[DESC_W-1:SECT_KEEP], va_off}};
            end
            default: kind = L1K_FAULT;
        endcase
    end

endmodule

// File: rtl/iopt_l2_decode.sv
// Second-level descriptor decoder.
// Builds a large or small page translation, or a page fault for type 0 or 3.
module iopt_l2_decode
    import iopt_pkg::*;
(
    input  logic [DESC_W-1:0]      desc,
    input  logic [LARGE_SHIFT-1:0] va_off,
    output walk_res_t              res
);

    logic [L2_TYPE_W-1:0] typ;
    logic                 unused_l2_bits;

    assign typ            = desc[L2_TYPE_W-1:0];
    assign unused_l2_bits = ^desc[SMALL_KEEP-1:L2_TYPE_W];

    // Decode the two-bit type and assemble the page translation
    always_comb begin
        res = '{fault: 1'b1, code: FLT_PAGE, size: SZ_SMALL, paddr: '0};
        case (typ)
            2'd1: res = '{fault: 1'b0, code: FLT_WALK, size: SZ_LARGE,
                          paddr: {desc[DESC_W-1:LARGE_KEEP], va_off}};
            2'd2: res = '{fault: 1'b0, code: FLT_WALK, size: SZ_SMALL,
                          paddr: {desc[DESC_W-1:SMALL_KEEP], va_off[L2_SHIFT-1:0]}};
            default: res.fault = 1'b1;
        endcase
    end

endmodule

// File: rtl/iopt_walker.sv
// Two-level IO table walker, top level.
// Takes one translation at a time and issues at most one descriptor read at a time.
// Holds the result until the client accepts it.
// Assumes memory answers every accepted read exactly once and in order.
module iopt_walker
    import iopt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [PA_W-1:0]   tbl_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [CODE_W-1:0] rsp_code,
    output logic [1:0]        rsp_size,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_write
);

    walk_st_e          state;
    logic [VA_W-1:0]   va_q;
    logic [PA_W-1:0]   base_q;
    logic              wr_q;
    logic [TBL_W-1:0]  tbl_q;
    walk_res_t         res_q;

    l1_kind_e          l1_kind;
    walk_res_t         l1_res;
    walk_res_t         l2_res;
    walk_res_t         err_res;

    iopt_addr_gen i_addr (
        .tbl_base (base_q),
        .vaddr    (va_q),
        .l2_tbl   (tbl_q),
        .sel_l2   (state == ST_L2_REQ),
        .rd_addr  (mem_req_addr)
    );

    iopt_l1_decode i_l1 (
        .desc   (mem_rsp_data),
        .va_off (va_q[L1_SHIFT-1:0]),
        .kind   (l1_kind),
        .res    (l1_res)
    );

    iopt_l2_decode i_l2 (
        .desc   (mem_rsp_data),
        .va_off (va_q[LARGE_SHIFT-1:0]),
        .res    (l2_res)
    );

    // Result reported when a descriptor read comes back with an error
    always_comb begin
        err_res = '{fault: 1'b1, code: FLT_WALK, size: SZ_SMALL, paddr: '0};
    end

    // Handshake outputs follow the walk state
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
        rsp_valid     = (state == ST_DONE);
        rsp_fault     = res_q.fault;
        rsp_code      = res_q.code;
        rsp_size      = res_q.size;
        rsp_paddr     = res_q.paddr;
        rsp_write     = wr_q;
    end

    // Walk sequencer: capture the request, issue reads, latch the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            va_q   <= '0;
            base_q <= '0;
            wr_q   <= 1'b0;
            tbl_q  <= '0;
            res_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        base_q <= tbl_base;
                        wr_q   <= req_write;
                        state  <= ST_L1_REQ;
                    end
                end
                ST_L1_REQ: begin
                    if (mem_req_ready) state <= ST_L1_WAIT;
                end
                ST_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            res_q <= err_res;
                            state <= ST_DONE;
                        end else if (l1_kind == L1K_TABLE) begin
                            tbl_q <= mem_rsp_data[DESC_W-1:L2_TBL_LOW];
                            state <= ST_L2_REQ;
                        end else begin
                            res_q <= l1_res;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_L2_REQ: begin
                    if (mem_req_ready) state <= ST_L2_WAIT;
                end
                ST_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        res_q <= mem_rsp_err ? err_res : l2_res;
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/iopt_walker_chk.sv
// Property checker for the IO table walker.
// It sees only the walker's ports, plus a copy of the accepted address offset.
module iopt_walker_chk
    import iopt_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [L1_SHIFT-1:0] req_off,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic [PA_W-1:0]     mem_req_addr,
    input logic                rsp_valid,
    input logic                rsp_ready,
    input logic                rsp_fault,
    input logic [CODE_W-1:0]   rsp_code,
    input logic [1:0]          rsp_size,
    input logic [PA_W-1:0]     rsp_paddr,
    input logic                rsp_write
);

    logic [L1_SHIFT-1:0] off_cap;

    // Remember the low address bits of the request being walked
    always_ff @(posedge clk) begin
        if (!rst_n) off_cap <= '0;
        else if (req_valid && req_ready) off_cap <= req_off;
    end

    p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || rsp_valid) |-> !req_ready);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_fault_pa_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_size == 2'd0));

    p_sect_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && rsp_size == 2'd2) |-> (rsp_paddr[L1_SHIFT-1:0] == off_cap));

    p_large_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && rsp_size == 2'd1)
        |-> (rsp_paddr[LARGE_SHIFT-1:0] == off_cap[LARGE_SHIFT-1:0]));

    p_small_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && rsp_size == 2'd0)
        |-> (rsp_paddr[L2_SHIFT-1:0] == off_cap[L2_SHIFT-1:0]));

    p_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_code == 3'd0 || rsp_code == 3'd1));

    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req_valid);

    p_hold_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready)
        |=> (rsp_valid && $stable({rsp_fault, rsp_code, rsp_size, rsp_paddr, rsp_write})));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> req_ready);

endmodule

bind iopt_walker iopt_walker_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_off       (req_vaddr[iopt_pkg::L1_SHIFT-1:0]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_code      (rsp_code),
    .rsp_size      (rsp_size),
    .rsp_paddr     (rsp_paddr),
    .rsp_write     (rsp_write)
);

// File: tb/test_iopt_walker.sv
`timescale 1ns/1ps
module test_iopt_walker;
    import iopt_pkg::*;

    typedef struct packed {
        logic [31:0] va;
        logic [35:0] base;
        logic [31:0] d1;
        logic [31:0] d2;
        logic        e1;
        logic        e2;
        logic        wr;
        logic [1:0]  reads;
        logic [35:0] a1;
        logic [35:0] a2;
        logic        fault;
        logic [2:0]  code;
        logic [1:0]  size;
        logic [35:0] pa;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5678, 36'h8_0000_4000, 32'hABCD_0002, 32'h0, 1'b0, 1'b0, 1'b0, 2'd1,
          36'h8_0000_448C, 36'h0, 1'b0, 3'd0, 2'd2, 36'hA_BCD4_5678},
        '{32'h0000_1000, 36'h8_0000_4000, 32'hFFFF_FFF8, 32'h0, 1'b0, 1'b0, 1'b1, 2'd1,
          36'h8_0000_4000, 36'h0, 1'b1, 3'd1, 2'd0, 36'h0},
        '{32'hFFF0_0000, 36'h8_0000_4000, 32'h1234_0003, 32'h0, 1'b0, 1'b0, 1'b0, 2'd1,
          36'h8_0000_7FFC, 36'h0, 1'b1, 3'd1, 2'd0, 36'h0},
        '{32'h0010_0000, 36'h8_0000_4000, 32'h0000_0006, 32'h0, 1'b0, 1'b0, 1'b0, 2'd1,
          36'h8_0000_4004, 36'h0, 1'b1, 3'd1, 2'd0, 36'h0},
        '{32'h0020_0000, 36'h8_0000_4000, 32'h0000_0002, 32'h0, 1'b1, 1'b0, 1'b1, 2'd1,
          36'h8_0000_4008, 36'h0, 1'b1, 3'd0, 2'd0, 36'h0},
        '{32'h0345_6789, 36'h8_0000_4000, 32'h0567_8041, 32'h9876_5001, 1'b0, 1'b0, 1'b1, 2'd2,
          36'h8_0000_40D0, 36'h0_5678_0558, 1'b0, 3'd0, 2'd1, 36'h9_8765_6789},
        '{32'h034F_FABC, 36'h8_0000_4000, 32'h0567_8041, 32'h1122_3302, 1'b0, 1'b0, 1'b0, 2'd2,
          36'h8_0000_40D0, 36'h0_5678_07FC, 1'b0, 3'd0, 2'd0, 36'h1_1223_3ABC},
        '{32'h0340_0000, 36'h8_0000_4000, 32'h0567_8041, 32'hFFFF_FFFC, 1'b0, 1'b0, 1'b0, 2'd2,
          36'h8_0000_40D0, 36'h0_5678_0400, 1'b1, 3'd1, 2'd0, 36'h0},
        '{32'h0341_0000, 36'h8_0000_4000, 32'h0567_8041, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 2'd2,
          36'h8_0000_40D0, 36'h0_5678_0440, 1'b1, 3'd1, 2'd0, 36'h0},
        '{32'h0342_0000, 36'h8_0000_4000, 32'h0567_8041, 32'h0000_0002, 1'b0, 1'b1, 1'b0, 2'd2,
          36'h8_0000_40D0, 36'h0_5678_0480, 1'b1, 3'd0, 2'd0, 36'h0},
        '{32'h0000_0000, 36'h0_0000_0000, 32'h0000_0002, 32'h0, 1'b0, 1'b0, 1'b0, 2'd1,
          36'h0_0000_0000, 36'h0, 1'b0, 3'd0, 2'd2, 36'h0},
        '{32'hFFFF_FFFF, 36'h0_0000_0000, 32'hFFFF_000A, 32'h0, 1'b0, 1'b0, 1'b1, 2'd1,
          36'h0_0000_3FFC, 36'h0, 1'b0, 3'd0, 2'd2, 36'hF_FFFF_FFFF},
        '{32'hFFFA_BCDE, 36'h0_FFFF_F000, 32'h0000_0012, 32'h0, 1'b0, 1'b0, 1'b0, 2'd1,
          36'h1_0000_2FFC, 36'h0, 1'b0, 3'd0, 2'd2, 36'h0_000A_BCDE}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        req_write;
    logic [35:0] tbl_base;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [35:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        mem_rsp_err;
    logic        rsp_valid;
    logic        rsp_ready;
    logic        rsp_fault;
    logic [2:0]  rsp_code;
    logic [1:0]  rsp_size;
    logic [35:0] rsp_paddr;
    logic        rsp_write;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    iopt_walker i_iopt_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .tbl_base      (tbl_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_fault     (rsp_fault),
        .rsp_code      (rsp_code),
        .rsp_size      (rsp_size),
        .rsp_paddr     (rsp_paddr),
        .rsp_write     (rsp_write)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            1, 2, 3:          return "R3";
            4, 9:             return "R7";
            5, 6, 7, 8:       return "R6";
            default:          return "R4";
        endcase
    endfunction

    // One translation; stall>0 also holds a junk request high while busy
    task automatic run(input vec_t v, input int stall, input int hold, input string tag);
        int          nreads = 0;
        bit          pend = 1'b0;
        int          left = stall;
        bit          busy_ok = 1'b1;
        bit          addr_stable = 1'b1;
        bit          seen = 1'b0;
        bit          got = 1'b0;
        int          lat = 0;
        logic [35:0] first_addr = '0;
        logic [35:0] pa_seen;
        logic [35:0] exp_addr;
        req_vaddr     = v.va;
        tbl_base      = v.base;
        req_write     = v.wr;
        req_valid     = 1'b1;
        mem_req_ready = (stall == 0);
        for (int c = 1; c <= 60 && !got; c++) begin
            @(negedge clk);
            if (c == 1) begin
                if (stall == 0) req_valid = 1'b0;
                else begin
                    req_vaddr = ~v.va;
                    req_write = ~v.wr;
                end
            end
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = (nreads == 1) ? v.d1 : v.d2;
                mem_rsp_err   = (nreads == 1) ? v.e1 : v.e2;
                pend = 1'b0;
            end else if (mem_req_valid) begin
                if (!seen) begin
                    first_addr = mem_req_addr;
                    seen = 1'b1;
                end else if (mem_req_addr != first_addr) addr_stable = 1'b0;
                if (left > 0) begin
                    mem_req_ready = 1'b0;
                    left--;
                end else begin
                    mem_req_ready = 1'b1;
                    exp_addr = (nreads == 0) ? v.a1 : v.a2;
                    chk(mem_req_addr == exp_addr, (nreads == 0) ? "R2" : "R5",
                        64'(mem_req_addr), 64'(exp_addr));
                    nreads++;
                    pend = 1'b1;
                    seen = 1'b0;
                end
            end
            if (rsp_valid) begin
                got = 1'b1;
                lat = c;
            end else if (req_ready) busy_ok = 1'b0;
        end
        req_valid = 1'b0;
        chk(got, "R10", 64'(got), 64'd1);
        chk(rsp_fault == v.fault, tag, 64'(rsp_fault), 64'(v.fault));
        chk(rsp_code == v.code, tag, 64'(rsp_code), 64'(v.code));
        chk(rsp_size == v.size, tag, 64'(rsp_size), 64'(v.size));
        chk(rsp_paddr == v.pa, tag, 64'(rsp_paddr), 64'(v.pa));
        chk(rsp_write == v.wr, "R9", 64'(rsp_write), 64'(v.wr));
        chk(nreads == int'(v.reads), "R7", 64'(nreads), 64'(v.reads));
        if (stall == 0)
            chk(lat == ((v.reads == 2'd2) ? 5 : 3), "R10", 64'(lat), 64'((v.reads == 2'd2) ? 5 : 3));
        else begin
            chk(busy_ok, "R1", 64'(busy_ok), 64'd1);
            chk(addr_stable, "R8", 64'(addr_stable), 64'd1);
        end
        pa_seen = rsp_paddr;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == pa_seen && !mem_req_valid, "R9",
                64'(rsp_paddr), 64'(pa_seen));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready && !rsp_valid, "R9", 64'({req_ready, rsp_valid}), 64'b10);
        mem_req_ready = 1'b1;
    endtask

    initial begin
        rst_n         = 1'b0;
        req_valid     = 1'b0;
        req_vaddr     = '0;
        req_write     = 1'b0;
        tbl_base      = '0;
        mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        mem_rsp_err   = 1'b0;
        rsp_ready     = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready, "R1", 64'(req_ready), 64'd1);
        chk(!rsp_valid && !mem_req_valid, "R8", 64'({rsp_valid, mem_req_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) run(VECS[i], 0, 0, tag_of(i));
        run(VECS[5], 3, 4, "R6");
        run(VECS[0], 0, 2, "R4");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule